// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block steers a set of device interrupt request lines to several processors. Devices report line changes as single events on a valid/ready stream. Each event either raises one line or drops one line. The block records these in a shared raw request register. Each processor owns a mask register. A processor's routed value is its mask ANDed with the raw requests, so one request can reach any subset of processors. Each processor has one registered, level-sensitive interrupt output. That output is high while its routed value is non-zero.

Software reaches the registers over a simple memory-mapped port that is 64 bits wide. The port takes a byte offset from the block base. The register index is that offset shifted right by six, so registers sit 64 bytes apart and the low six offset bits are ignored. Masks can be read and written. Routed values and the raw request register can only be read. Any access that is not a full 64-bit access is rejected. Any access to an index with no register behind it is also rejected.

Top module: `irq_router`

## Requirements
- R1: After reset every mask and the raw request register read as zero, every `cpu_irq` bit is low, and `bus_err` and `bus_rvalid` are low.
- R2: An accepted event with `evt_raise`=1 sets bit `evt_line` of the raw request register on the next clock edge. `evt_ready` is always 1, so the stream never applies back-pressure and every event with `evt_valid`=1 is accepted in its own cycle.
- R3: An accepted event with `evt_raise`=0 clears bit `evt_line` of the raw request register. Dropping a line whose bit is already clear changes no register and no output. The raw request register changes only through events.
- R4: A legal write to index c (0 ≤ c < NUM_CPU) loads `bus_wdata` into processor c's mask. A read of that index returns the mask.
- R5: A read of index NUM_CPU+c returns processor c's mask ANDed with the raw request register, as it stood before the edge that samples the read.
- R6: `cpu_irq[c]` equals the OR of all bits of processor c's routed value. It follows any change of that value exactly one clock later.
- R7: Writing a mask that unmasks a pending raw request raises that processor's `cpu_irq` bit one clock after the write takes effect. Writing a mask that removes the last routed bit lowers it one clock after the write takes effect.
- R8: Index 2·NUM_CPU reads the raw request register. The index is the byte offset shifted right by 6, and offset bits [5:0] do not affect decoding.
- R9: `bus_size` encodes 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit. Any access with `bus_size`≠3 pulses `bus_err` for one cycle, leaves every register unchanged, and returns zero if it is a read.
- R10: A write to a routed index or to the raw request index pulses `bus_err` and changes no register.
- R11: A read or write of an index above 2·NUM_CPU pulses `bus_err`. Such a read returns zero.
- R12: Every read request produces `bus_rvalid`=1 with `bus_rdata` in the following cycle. `bus_err` for any request appears in that same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A line event is offered |
| evt_ready | output | 1 | Event accepted (always 1) |
| evt_raise | input | 1 | 1 raises the line, 0 drops it |
| evt_line | input | $clog2(NUM_LINES) | Line number of the event |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | ADDR_W | Byte offset from block base |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | NUM_LINES | Read data |
| bus_err | output | 1 | One-cycle error pulse for a rejected access |
| cpu_irq | output | NUM_CPU | Per-processor device interrupt level |

## Verification
The hardest situation to reach from the ports is one where a mask write and a line event land in the same cycle on the same processor. Here the output must react to the old state on one edge and to the combined new state on the next. It is equally hard to reach the point where a processor loses its last routed bit while other processors still hold the same line. The directed phase builds overlapping masks so that one line is shared by several processors. It then drops lines and rewrites masks one at a time. A long mixed phase drives events and bus accesses together on the same edges, aimed at a small set of lines so that collisions are frequent. A behavioural model is compared on every clock throughout.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned IDX_SHIFT = 6;

  typedef enum logic [1:0] {
    ACC_B8  = 2'd0,
    ACC_B16 = 2'd1,
    ACC_B32 = 2'd2,
    ACC_B64 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    KIND_MASK   = 2'd0,
    KIND_ROUTED = 2'd1,
    KIND_RAW    = 2'd2,
    KIND_NONE   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned IDX_W   = 6,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             write,
  input  logic [1:0]       size,
  output reg_kind_e        kind,
  output logic [CPU_W-1:0] cpu_sel,
  output logic             legal
);
  logic [IDX_W-1:0] rel;
  logic             unused_rel_hi;

  always_comb begin
    if (idx < IDX_W'(NUM_CPU))            kind = KIND_MASK;
    else if (idx < IDX_W'(2 * NUM_CPU))   kind = KIND_ROUTED;
    else if (idx == IDX_W'(2 * NUM_CPU))  kind = KIND_RAW;
    else                                  kind = KIND_NONE;
  end

  assign rel     = (kind == KIND_ROUTED) ? (idx - IDX_W'(NUM_CPU)) : idx;
  assign cpu_sel = rel[CPU_W-1:0];
  assign unused_rel_hi = ^rel;

  always_comb begin
    if (acc_size_e'(size) != ACC_B64) legal = 1'b0;
    else if (write)                   legal = (kind == KIND_MASK);
    else                              legal = (kind != KIND_NONE);
  end
endmodule

// File: rtl/irq_router_maskbank.sv
module irq_router_maskbank #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [CPU_W-1:0]                    wr_cpu,
  input  logic [NUM_LINES-1:0]                wr_data,
  output logic [NUM_CPU-1:0][NUM_LINES-1:0]   mask_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[c] <= '0;
      else if (wr_en && (wr_cpu == CPU_W'(c)))
        mask_q[c] <= wr_data;
    end
  end
endmodule

// File: rtl/irq_router_reqreg.sv
module irq_router_reqreg #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_fire,
  input  logic                 evt_raise,
  input  logic [LINE_W-1:0]    evt_line,
  output logic [NUM_LINES-1:0] raw_q
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        raw_q[n] <= 1'b0;
      else if (evt_fire && (evt_line == LINE_W'(n)))
        raw_q[n] <= evt_raise;
    end
  end
endmodule

// File: rtl/irq_router_route.sv
module irq_router_route #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0]              raw_q,
  output logic [NUM_CPU-1:0][NUM_LINES-1:0] routed,
  output logic [NUM_CPU-1:0]                irq_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign routed[c] = mask_q[c] & raw_q;

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[c] <= 1'b0;
      else        irq_q[c] <= |routed[c];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned IDX_W    = ADDR_W - IDX_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic                 evt_raise,
  input  logic [LINE_W-1:0]    evt_line,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic                 bus_rvalid,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 bus_err,
  output logic [NUM_CPU-1:0]   cpu_irq
);
  logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q;
  logic [NUM_CPU-1:0][NUM_LINES-1:0] routed;
  logic [NUM_LINES-1:0]              raw_q;
  logic [IDX_W-1:0]                  idx;
  reg_kind_e                         kind;
  logic [CPU_W-1:0]                  cpu_sel;
  logic                              legal;
  logic                              mask_wr;
  logic [NUM_LINES-1:0]              rd_value;
  logic                              unused_low_offset;

  assign evt_ready = 1'b1;
  assign idx       = bus_addr[ADDR_W-1:IDX_SHIFT];
  assign unused_low_offset = ^bus_addr[IDX_SHIFT-1:0];

  irq_router_decode #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_decode (
    .idx     (idx),
    .write   (bus_write),
    .size    (bus_size),
    .kind    (kind),
    .cpu_sel (cpu_sel),
    .legal   (legal)
  );

  assign mask_wr = bus_valid && bus_write && legal;

  irq_router_maskbank #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_masks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wr_cpu  (cpu_sel),
    .wr_data (bus_wdata),
    .mask_q  (mask_q)
  );

  irq_router_reqreg #(.NUM_LINES(NUM_LINES)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_fire  (evt_valid && evt_ready),
    .evt_raise (evt_raise),
    .evt_line  (evt_line),
    .raw_q     (raw_q)
  );

  irq_router_route #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_q (mask_q),
    .raw_q  (raw_q),
    .routed (routed),
    .irq_q  (cpu_irq)
  );

  always_comb begin
    rd_value = '0;
    if (legal) begin
      unique case (kind)
        KIND_MASK:   rd_value = mask_q[cpu_sel];
        KIND_ROUTED: rd_value = routed[cpu_sel];
        KIND_RAW:    rd_value = raw_q;
        default:     rd_value = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      bus_err    <= bus_valid && !legal;
      if (bus_valid && !bus_write)
        bus_rdata <= rd_value;
    end
  end
endmodule

// File: rtl/irq_router_sva.sv
module irq_router_sva #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              evt_valid,
  input logic                              evt_raise,
  input logic [LINE_W-1:0]                 evt_line,
  input logic                              bus_valid,
  input logic                              bus_write,
  input logic [1:0]                        bus_size,
  input logic [ADDR_W-1:0]                 bus_addr,
  input logic [NUM_LINES-1:0]              bus_wdata,
  input logic                              bus_rvalid,
  input logic [NUM_LINES-1:0]              bus_rdata,
  input logic                              bus_err,
  input logic [NUM_CPU-1:0]                cpu_irq,
  input logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0]              raw_q
);
  logic             mask_idx_hit;
  logic [CPU_W-1:0] wr_cpu;

  assign mask_idx_hit = (bus_addr >> 6) < ADDR_W'(NUM_CPU);
  assign wr_cpu       = bus_addr[6 +: CPU_W];

  AST_RAISE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_raise |=> raw_q[$past(evt_line)]); // R2
  AST_DROP_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_raise |=> !raw_q[$past(evt_line)]); // R3
  AST_RAW_HELD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(raw_q)); // R3
  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_size == 2'd3 && mask_idx_hit
    |=> mask_q[$past(wr_cpu)] == $past(bus_wdata)); // R4
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size != 2'd3 |=> bus_err); // R9
  AST_NARROW_NO_MASK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size != 2'd3 |=> $stable(mask_q)); // R9
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err && bus_rvalid |-> bus_rdata == '0); // R11
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |=> bus_rvalid); // R12

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    AST_IRQ_FOLLOWS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cpu_irq[c] == $past(|(mask_q[c] & raw_q))); // R6
  end
endmodule

bind irq_router irq_router_sva #(
  .NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_raise(evt_raise),
  .evt_line(evt_line), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .cpu_irq(cpu_irq), .mask_q(mask_q), .raw_q(raw_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0, evt_raise = 1'b0;
  logic [5:0]    evt_line = '0;
  logic          evt_ready;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]    bus_size = 2'd3;
  logic [AW-1:0] bus_addr = '0;
  logic [NL-1:0] bus_wdata = '0;
  logic          bus_rvalid, bus_err;
  logic [NL-1:0] bus_rdata;
  logic [NC-1:0] cpu_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_router #(.NUM_CPU(NC), .NUM_LINES(NL), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_raise(evt_raise), .evt_line(evt_line), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .cpu_irq(cpu_irq)
  );

  // behavioural reference state
  logic [NL-1:0] m_mask [NC];
  logic [NL-1:0] m_raw;
  logic [NC-1:0] m_irq;
  logic          m_err, m_rvalid;
  logic [NL-1:0] m_rdata;

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mask[c]) m_mask[c] = '0;
      m_raw = '0; m_irq = '0; m_err = 0; m_rvalid = 0; m_rdata = '0;
    end else begin
      int idx;
      bit ok;
      logic [NL-1:0] val;
      for (int c = 0; c < NC; c++) m_irq[c] = |(m_mask[c] & m_raw);
      idx = int'(bus_addr) / 64;
      if (bus_size != 2'd3) ok = 0;
      else if (bus_write) ok = (idx < NC);
      else ok = (idx <= 2 * NC);
      val = '0;
      if (ok && !bus_write) begin
        if (idx < NC) val = m_mask[idx];
        else if (idx < 2 * NC) val = m_mask[idx - NC] & m_raw;
        else val = m_raw;
      end
      m_err = bus_valid && !ok;
      m_rvalid = bus_valid && !bus_write;
      if (m_rvalid) m_rdata = val;
      if (bus_valid && bus_write && ok) m_mask[idx] = bus_wdata;
      if (evt_valid) m_raw[evt_line] = evt_raise;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 cpu_irq", NL'(cpu_irq), NL'(m_irq));
      check("R9 bus_err", NL'(bus_err), NL'(m_err));
      check("R12 bus_rvalid", NL'(bus_rvalid), NL'(m_rvalid));
      check("R2 evt_ready", NL'(evt_ready), NL'(1));
      if (m_rvalid) check("R5 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic bus_op(input bit wr, input int idx, input int low,
                        input logic [1:0] sz, input logic [NL-1:0] wd,
                        output logic [NL-1:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_size = sz;
    bus_addr = AW'(idx * 64 + low); bus_wdata = wd;
    @(negedge clk);
    bus_valid = 0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic event_op(input bit up, input int line);
    @(negedge clk);
    evt_valid = 1; evt_raise = up; evt_line = 6'(line);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [NL-1:0] exp);
    logic [NL-1:0] d; logic e;
    bus_op(0, idx, 0, 2'd3, '0, d, e);
    check(req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] d; logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", NL'(cpu_irq), '0);
    check("R1 err after reset", NL'(bus_err), '0);
    for (int c = 0; c < NC; c++) rd_chk("R1 mask zero", c, '0);
    rd_chk("R1 raw zero", 2 * NC, '0);

    bus_op(1, 0, 0, 2'd3, 64'h0000_0000_0000_00FF, d, e);
    bus_op(1, 1, 0, 2'd3, 64'h8000_0000_0000_0001, d, e);
    bus_op(1, 2, 0, 2'd3, '1, d, e);
    bus_op(1, 3, 0, 2'd3, '0, d, e);
    rd_chk("R4 mask1 readback", 1, 64'h8000_0000_0000_0001);
    rd_chk("R8 mask1 via offset bits", 1, 64'h8000_0000_0000_0001);
    bus_op(0, 1, 63, 2'd3, '0, d, e);
    check("R8 low offset ignored", d, 64'h8000_0000_0000_0001);

    event_op(1, 3);
    @(negedge clk);
    check("R2 cpu0 and cpu2 see line 3", NL'(cpu_irq), NL'(4'b0101));
    event_op(1, 63);
    @(negedge clk);
    check("R2 line 63 reaches cpu1", NL'(cpu_irq), NL'(4'b0111));
    rd_chk("R8 raw read", 2 * NC, 64'h8000_0000_0000_0008);
    rd_chk("R5 routed cpu1", NC + 1, 64'h8000_0000_0000_0000);
    event_op(0, 5);
    rd_chk("R3 spurious drop no change", 2 * NC, 64'h8000_0000_0000_0008);
    event_op(0, 3);
    @(negedge clk);
    check("R3 drop lowers cpu0", NL'(cpu_irq), NL'(4'b0110));

    bus_op(1, 3, 0, 2'd3, 64'h8000_0000_0000_0000, d, e);
    @(negedge clk);
    check("R7 unmask pending raises cpu3", NL'(cpu_irq[3]), NL'(1));
    bus_op(1, 1, 0, 2'd3, '0, d, e);
    @(negedge clk);
    check("R7 mask last bit lowers cpu1", NL'(cpu_irq[1]), NL'(0));

    bus_op(1, 0, 0, 2'd2, '1, d, e);
    check("R9 narrow write error", NL'(e), NL'(1));
    rd_chk("R9 mask unchanged", 0, 64'h0000_0000_0000_00FF);
    bus_op(0, 0, 0, 2'd0, '0, d, e);
    check("R9 narrow read zero", d, '0);
    bus_op(1, NC + 2, 0, 2'd3, '1, d, e);
    check("R10 routed write error", NL'(e), NL'(1));
    bus_op(1, 2 * NC, 0, 2'd3, '1, d, e);
    check("R10 raw write error", NL'(e), NL'(1));
    rd_chk("R10 raw unchanged", 2 * NC, 64'h8000_0000_0000_0000);
    bus_op(0, 2 * NC + 1, 0, 2'd3, '0, d, e);
    check("R11 undecoded read error", NL'(e), NL'(1));
    check("R11 undecoded read zero", d, '0);
    bus_op(0, 40, 0, 2'd3, '0, d, e);
    check("R11 high index zero", d, '0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      evt_valid = ($urandom_range(0, 2) != 0);
      evt_raise = $urandom_range(0, 1) != 0;
      evt_line  = 6'($urandom_range(0, 7) + 56 * $urandom_range(0, 1));
      bus_valid = ($urandom_range(0, 1) != 0);
      bus_write = $urandom_range(0, 1) != 0;
      bus_size  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
      bus_addr  = AW'($urandom_range(0, 2 * NC + 1) * 64 + $urandom_range(0, 63));
      bus_wdata = {$urandom, $urandom} & 64'hFF00_0000_0000_00FF;
    end
    @(negedge clk);
    evt_valid = 0; bus_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule